// File: doc/BRIEF.md
# Synchronous Character Receiver with SYN Hunt

This block turns a bit-serial line into characters. The line is clocked by a 1X receive clock, and each character is 5 to 8 bits long. Bits arrive least significant bit first, and the block samples the data bit on every rising edge of the receive clock. The block runs on its own system clock, which must be several times faster than the receive clock, and it finds the rising edges of the receive clock by sampling it.

A rising edge on the enable starts a bit-by-bit hunt for a programmable first SYN pattern. If double-SYN framing is selected, the very next character must equal the second SYN pattern. Once the line is in sync, each assembled character is offered on a valid/ready output stream.

The output stream has no back-pressure on the line: a serial line cannot be stalled. A new character that arrives while the previous one is still waiting overwrites it and raises an overrun flag. A character is consumed in any cycle where `out_valid` and `out_ready` are both high.

A select input replaces the internal SYN search with an external sync pulse. A SYN-detect flag and the overrun flag stay set until a status read.

Top module: `sync_char_rx`

## Requirements
- R1: While `rx_en` is low the receiver is idle and delivers no character. A low-to-high change of `rx_en` restarts the hunt, and the hunt then needs fresh bits.
- R2: `char_len` gives the character length: 0, 1, 2 and 3 mean 5, 6, 7 and 8 bits. In the hunt, the last `char_len+5` received bits are compared with the same number of low bits of `syn1` after every bit. In single-SYN mode (`dbl_syn`=0) a match sets `syn_det` and starts assembly with the next bit.
- R3: In double-SYN mode, the character that follows the SYN1 match must equal the low bits of `syn2`; only then are `syn_det` set and sync reached. Any other character returns the receiver to the hunt, so the sequence SYN1, SYN1, SYN2 does not reach sync.
- R4: The SYN characters that establish sync are never delivered on the output.
- R5: Once in sync, every assembled character is delivered with `out_valid` high. The first received bit is bit 0, and bits above the character length read as zero.
- R6: When `strip_syn` is high and the line is in sync, characters that form a SYN sequence are dropped. In single-SYN mode this is a SYN1. In double-SYN mode it is a SYN1, or a SYN2 that directly follows a SYN1. When `strip_syn` is low these characters are delivered. Either way, a complete SYN sequence sets `syn_det` again.
- R7: With `ext_sync_sel` high, internal SYN detection and stripping are off. A rising edge of `ext_sync` makes the receiver sync at the next rising edge of the receive clock, and the bit sampled at that edge is bit 0 of the first character.
- R8: Once set, `syn_det` stays set until `stat_rd` is pulsed.
- R9: A character that completes while `out_valid` is high and `out_ready` is low replaces `out_data` and sets `overrun`. `overrun` is cleared by `stat_rd`.
- R10: `out_valid` falls after a cycle in which both `out_valid` and `out_ready` are high, unless a new character arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxc | input | 1 | 1X receive clock; data is sampled on its rising edge |
| rxd | input | 1 | Serial data |
| rx_en | input | 1 | Receiver enable; a rising edge restarts the hunt |
| char_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| dbl_syn | input | 1 | 1 = double-SYN framing |
| strip_syn | input | 1 | 1 = drop SYN characters once in sync |
| syn1 | input | 8 | First SYN pattern |
| syn2 | input | 8 | Second SYN pattern |
| ext_sync_sel | input | 1 | 1 = external sync replaces the SYN search |
| ext_sync | input | 1 | External sync pulse; its rising edge is used |
| out_ready | input | 1 | Consumer accepts the character |
| stat_rd | input | 1 | Status read; clears `syn_det` and `overrun` |
| out_data | output | 8 | Received character, zero above its length |
| out_valid | output | 1 | A character is waiting |
| syn_det | output | 1 | A SYN sequence or an external sync was seen |
| overrun | output | 1 | A waiting character was overwritten |

## Verification
A wrong hunt or sync state shows up at the ports within one character time. Either `syn_det` fails to rise at the end of the SYN pattern, or a character appears that should have been held back or dropped. A bit-counter or alignment error corrupts the very first delivered character, because every bit after it is shifted by the same amount. The bench therefore compares each character against the value it sent, two system cycles after the last bit edge. It also checks the sticky flags at each point where a status read or a second character could change them.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    ST_OFF,
    ST_HUNT,
    ST_WAIT2,
    ST_SYNC
  } rx_state_e;
endpackage

// File: rtl/sc_edge.sv
// Rising-edge detectors for a bundle of slow inputs sampled on clk.
module sc_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise
);
  logic [W-1:0] q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= d[g];
    end
    assign rise[g] = d[g] & ~q[g];
  end
endmodule

// File: rtl/sc_framer.sv
// Hunt, SYN checking and character assembly; emits one-cycle events.
module sc_framer
  import scr_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              en_rise,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              dbl_syn,
  input  logic              strip_syn,
  input  logic [CHAR_W-1:0] syn1,
  input  logic [CHAR_W-1:0] syn2,
  input  logic              ext_sel,
  input  logic              ext_rise,
  output logic              char_ev,
  output logic [CHAR_W-1:0] char_data,
  output logic              syn_ev
);
  localparam int CNT_W = $clog2(CHAR_W + 1);
  localparam logic [CNT_W-1:0] CW = CNT_W'(CHAR_W);

  rx_state_e         st, st_d;
  logic [CHAR_W-1:0] sh, sh_d, sh_nx, cur, msk, s1m, s2m, data_d;
  logic [CNT_W-1:0]  cnt, cnt_d, cnt_inc, need;
  logic              pend, pend_d, arm, jam, full, cev_d, sev_d, is1, is2;

  assign need    = CNT_W'(char_len) + CNT_W'(MIN_LEN);
  assign sh_nx   = {rxd, sh[CHAR_W-1:1]};
  assign cur     = sh_nx >> (CW - need);
  assign msk     = {CHAR_W{1'b1}} >> (CW - need);
  assign s1m     = syn1 & msk;
  assign s2m     = syn2 & msk;
  assign cnt_inc = cnt + CNT_W'(1);
  assign full    = cnt_inc >= need;
  assign is1     = cur == s1m;
  assign is2     = pend && (cur == s2m);
  assign jam     = ext_sel && arm && bit_tick && (st != ST_OFF);

  always_comb begin
    st_d   = st;
    sh_d   = sh;
    cnt_d  = cnt;
    pend_d = pend;
    cev_d  = 1'b0;
    sev_d  = 1'b0;
    data_d = char_data;
    if (!rx_en) begin
      st_d = ST_OFF; cnt_d = '0; pend_d = 1'b0;
    end else if (en_rise) begin
      st_d = ST_HUNT; cnt_d = '0; pend_d = 1'b0;
    end else if (jam) begin
      st_d = ST_SYNC; sh_d = sh_nx; cnt_d = CNT_W'(1); pend_d = 1'b0; sev_d = 1'b1;
    end else if (bit_tick && st != ST_OFF) begin
      sh_d = sh_nx;
      unique case (st)
        ST_HUNT: begin
          if (!ext_sel) begin
            cnt_d = full ? need : cnt_inc;
            if (full && is1) begin
              cnt_d = '0;
              if (dbl_syn) st_d = ST_WAIT2;
              else begin st_d = ST_SYNC; sev_d = 1'b1; end
            end
          end
        end
        ST_WAIT2: begin
          cnt_d = cnt_inc;
          if (full) begin
            cnt_d = '0;
            if (cur == s2m) begin st_d = ST_SYNC; sev_d = 1'b1; end
            else st_d = ST_HUNT;
          end
        end
        default: begin
          cnt_d = cnt_inc;
          if (full) begin
            cnt_d  = '0;
            data_d = cur;
            if (ext_sel) cev_d = 1'b1;
            else if (dbl_syn) begin
              sev_d  = is2;
              pend_d = is1;
              cev_d  = !(strip_syn && (is1 || is2));
            end else begin
              sev_d = is1;
              cev_d = !(strip_syn && is1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_OFF; sh <= '0; cnt <= '0; pend <= 1'b0; arm <= 1'b0;
      char_ev <= 1'b0; syn_ev <= 1'b0; char_data <= '0;
    end else begin
      st <= st_d; sh <= sh_d; cnt <= cnt_d; pend <= pend_d;
      char_ev <= cev_d; syn_ev <= sev_d; char_data <= data_d;
      if (!rx_en || en_rise)      arm <= 1'b0;
      else if (ext_sel && ext_rise) arm <= 1'b1;
      else if (jam)               arm <= 1'b0;
    end
  end

  // R1: nothing is produced while disabled
  assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !char_ev);
  // R4: hunting never hands out a character
  assert_hunt_no_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT || st == ST_WAIT2) |=> !char_ev);
  // R5: bits above the character length are zero
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_ev) || (char_ev && $past(char_ev)) |-> (char_data >> $past(need)) == '0);
endmodule

// File: rtl/sc_hold.sv
// Holding register with valid/ready output and sticky status flags.
module sc_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_ev,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              syn_ev,
  input  logic              out_ready,
  input  logic              stat_rd,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid,
  output logic              syn_det,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0; out_valid <= 1'b0; syn_det <= 1'b0; overrun <= 1'b0;
    end else begin
      if (char_ev) begin
        out_data  <= char_data;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (char_ev && out_valid && !out_ready) overrun <= 1'b1;
      else if (stat_rd)                       overrun <= 1'b0;
      if (syn_ev)       syn_det <= 1'b1;
      else if (stat_rd) syn_det <= 1'b0;
    end
  end

  // R8: the sync flag only drops on a status read
  assert_syn_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    syn_det && !stat_rd |=> syn_det);
  // R9: overrun only rises when a waiting character existed
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !overrun ##1 overrun |-> $past(out_valid));
  // R10: an unaccepted character stays offered
  assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx #(
  parameter int CHAR_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxc,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              dbl_syn,
  input  logic              strip_syn,
  input  logic [CHAR_W-1:0] syn1,
  input  logic [CHAR_W-1:0] syn2,
  input  logic              ext_sync_sel,
  input  logic              ext_sync,
  input  logic              out_ready,
  input  logic              stat_rd,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid,
  output logic              syn_det,
  output logic              overrun
);
  logic [2:0]        rises;
  logic              char_ev, syn_ev;
  logic [CHAR_W-1:0] char_data;

  sc_edge #(.W(3)) i_edge (
    .clk(clk), .rst_n(rst_n), .d({ext_sync, rx_en, rxc}), .rise(rises)
  );

  sc_framer #(.CHAR_W(CHAR_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_framer (
    .clk(clk), .rst_n(rst_n), .bit_tick(rises[0]), .rxd(rxd), .rx_en(rx_en),
    .en_rise(rises[1]), .char_len(char_len), .dbl_syn(dbl_syn),
    .strip_syn(strip_syn), .syn1(syn1), .syn2(syn2), .ext_sel(ext_sync_sel),
    .ext_rise(rises[2]), .char_ev(char_ev), .char_data(char_data), .syn_ev(syn_ev)
  );

  sc_hold #(.CHAR_W(CHAR_W)) i_hold (
    .clk(clk), .rst_n(rst_n), .char_ev(char_ev), .char_data(char_data),
    .syn_ev(syn_ev), .out_ready(out_ready), .stat_rd(stat_rd),
    .out_data(out_data), .out_valid(out_valid), .syn_det(syn_det), .overrun(overrun)
  );
endmodule

// File: tb/test_sync_char_rx.sv
module test_sync_char_rx;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rxc = 1'b0, rxd = 1'b1, rx_en = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       dbl_syn = 1'b0, strip_syn = 1'b0, ext_sync_sel = 1'b0, ext_sync = 1'b0;
  logic [7:0] syn1 = 8'h16, syn2 = 8'h7E;
  logic       out_ready = 1'b0, stat_rd = 1'b0;
  logic [7:0] out_data;
  logic       out_valid, syn_det, overrun;
  int         total = 0, bad = 0;

  always #2 clk = ~clk;

  sync_char_rx i_sync_char_rx (
    .clk(clk), .rst_n(rst_n), .rxc(rxc), .rxd(rxd), .rx_en(rx_en),
    .char_len(char_len), .dbl_syn(dbl_syn), .strip_syn(strip_syn),
    .syn1(syn1), .syn2(syn2), .ext_sync_sel(ext_sync_sel), .ext_sync(ext_sync),
    .out_ready(out_ready), .stat_rd(stat_rd), .out_data(out_data),
    .out_valid(out_valid), .syn_det(syn_det), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lowbits(input logic [7:0] v, input int n);
    return v & 8'((1 << n) - 1);
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); rxc = 1'b0; rxd = b;
    repeat (2) @(negedge clk); rxc = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
    @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk); rx_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset valid", out_valid, 0);
    chk("R8 reset syn_det", syn_det, 0);
    chk("R9 reset overrun", overrun, 0);

    // R1: disabled receiver delivers nothing
    send_char(syn1, 8); send_char(8'hA5, 8);
    chk("R1 disabled no char", out_valid, 0);
    chk("R1 disabled no syn", syn_det, 0);

    // R2/R4: single SYN hunt, 8-bit characters
    restart(); idle_ones(3);
    send_char(syn1, 8);
    chk("R2 single syn_det", syn_det, 1);
    chk("R4 syn not delivered", out_valid, 0);
    rd_stat();
    chk("R8 cleared by read", syn_det, 0);
    for (int k = 0; k < 12; k++) begin
      v = 8'($urandom);
      send_char(v, 8);
      chk("R5 valid random", out_valid, 1);
      chk("R5 data random", out_data, v);
      pop();
      chk("R10 valid drops", out_valid, 0);
    end

    // R6: stripping in single-SYN mode
    rd_stat();
    strip_syn = 1'b1;
    send_char(syn1, 8);
    chk("R6 strip drops syn1", out_valid, 0);
    chk("R6 syn_det again", syn_det, 1);
    send_char(8'h3C, 8);
    chk("R6 data after strip", out_data, 8'h3C);
    pop();
    strip_syn = 1'b0;

    // R2/R5: 5-bit characters
    char_len = 2'd0;
    restart(); rd_stat(); idle_ones(4);
    send_char(syn1, 5);
    chk("R2 5-bit syn_det", syn_det, 1);
    chk("R4 5-bit syn hidden", out_valid, 0);
    for (int k = 0; k < 6; k++) begin
      v = 8'($urandom);
      send_char(v, 5);
      chk("R5 5-bit data upper zero", out_data, lowbits(v, 5));
      pop();
    end

    // R3: double SYN, SYN1 SYN1 SYN2 must not sync
    char_len = 2'd3; dbl_syn = 1'b1;
    restart(); rd_stat(); idle_ones(3);
    send_char(syn1, 8); send_char(syn1, 8); send_char(syn2, 8);
    chk("R3 syn1 syn1 syn2 no sync", syn_det, 0);
    send_char(8'h55, 8);
    chk("R3 still hunting", out_valid, 0);
    send_char(syn1, 8); send_char(syn2, 8);
    chk("R3 syn1 syn2 syncs", syn_det, 1);
    chk("R4 double syn hidden", out_valid, 0);
    send_char(8'hC8, 8);
    chk("R5 first char after double", out_data, 8'hC8);
    pop();

    // R6: double SYN in sync, no strip then strip
    rd_stat();
    send_char(syn1, 8);
    chk("R6 no strip syn1 delivered", out_data, syn1);
    pop();
    send_char(syn2, 8);
    chk("R6 no strip syn2 delivered", out_data, syn2);
    chk("R6 resync double", syn_det, 1);
    pop(); rd_stat();
    strip_syn = 1'b1;
    send_char(syn1, 8); send_char(syn2, 8);
    chk("R6 strip double drops", out_valid, 0);
    chk("R6 strip double syn_det", syn_det, 1);
    send_char(syn2, 8);
    chk("R6 lone syn2 kept", out_data, syn2);
    pop(); strip_syn = 1'b0; dbl_syn = 1'b0;

    // R9: overrun
    rd_stat();
    v = 8'($urandom); w = 8'($urandom);
    send_char(v, 8); send_char(w, 8);
    chk("R9 overrun set", overrun, 1);
    chk("R9 data overwritten", out_data, w);
    rd_stat();
    chk("R9 overrun cleared", overrun, 0);
    chk("R10 still valid", out_valid, 1);
    pop();
    chk("R10 consumed", out_valid, 0);

    // R7: external sync
    ext_sync_sel = 1'b1;
    restart(); rd_stat(); idle_ones(2);
    send_char(syn1, 8);
    chk("R7 internal hunt off", syn_det, 0);
    send_bit(1'b1); send_bit(1'b0);
    @(negedge clk); ext_sync = 1'b1;
    repeat (2) @(negedge clk); ext_sync = 1'b0;
    v = 8'($urandom);
    send_char(v, 8);
    chk("R7 jam char", out_data, v);
    chk("R7 jam syn_det", syn_det, 1);
    pop();
    send_char(syn1, 8);
    chk("R7 no strip in ext", out_data, syn1);
    chk("R8 ext syn_det stays", syn_det, 1);
    pop(); rd_stat();
    chk("R8 ext syn_det read", syn_det, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule